// File: doc/BRIEF.md
# Phase Token Ring Sequencer

This block sets the firing order of a multiphase converter. One shared clock runs the controller and a chain of phase slices. The controller sends a one-cycle token into the first slice. Each slice delays the token by one clock and hands it to the next slice. The output of the last slice returns to the controller. Each slice fires, which means it starts its switching cycle, on the clock in which it holds the token. Every phase therefore fires once per round of the ring.

After reset the controller sends one token and counts clocks until the token comes back. That latency is the number of active phases. Once the count is known, the controller sends a new token every N clocks. It checks that each return arrives in the same cycle as the next send. A missing, early or extra return latches a fault and stops the rotation.

Each slice has two controls. A slice set to bypass passes the token through with no delay and does not count as a phase. A slice set to debug keeps its timing in the ring but never fires. A cut on a link models a broken chain.

Top module: `phase_ring_seq`

## Requirements
- R1: While `rst` is high and after it is released, before the first active clock edge, `token_out`, `count_valid`, `chain_fault`, `phase_count` and `slice_fire` are all zero.
- R2: On the first clock edge with `rst` low, the controller raises `token_out` for exactly one cycle. This cycle is called cycle 0.
- R3: A slice that is not bypassed and not in debug raises its bit of `slice_fire` one clock after the token reaches its input. The j-th such slice in ring order (slice index 0 comes first) fires in cycle j of discovery.
- R4: A bypassed slice adds no delay, does not count as a phase and never fires. A cut on a bypassed slice has no effect.
- R5: With K active slices (K ≥ 1) and no cut among them, `phase_count` becomes K and `count_valid` rises in cycle K+1. The count then holds its value.
- R6: A slice in debug never fires, but it still delays the token by one clock, so the phase count and the firing times of the other slices do not change.
- R7: If the token has not returned when the clock count reaches TIMEOUT, `chain_fault` rises in cycle TIMEOUT+1 and `token_out` stays low from then on. A cut on an active slice causes this outcome.
- R8: If every slice is bypassed, the token returns in the cycle it was sent. `chain_fault` rises in cycle 1 and `count_valid` stays low.
- R9: After discovery the controller sends a token in cycle K+1 and then every K cycles. Each active slice fires once per K cycles, and only one slice fires in any cycle.
- R10: While rotating, a return that does not line up with a send (for example, after a cut appears) sets `chain_fault`, clears `count_valid` and stops the token. The fault stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared system clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_bypass | input | N_SLICES | Per-slice bypass: the slice is routed around |
| slice_debug | input | N_SLICES | Per-slice debug: the slice forwards the token but does not fire |
| link_cut | input | N_SLICES | Per-slice broken output link |
| token_out | output | 1 | Token sent by the controller into the first slice |
| phase_count | output | $clog2(TIMEOUT+1) | Discovered number of active phases |
| count_valid | output | 1 | `phase_count` is valid and the ring is rotating |
| chain_fault | output | 1 | Sticky fault flag for the ring |
| slice_fire | output | N_SLICES | Per-slice fire pulse |

## Verification
The assertions assume the bypass, debug and cut controls are fixed from reset onward, with one exception: a cut may appear on an active slice during rotation. Under that assumption, at most one token is in the ring and at most one slice fires per cycle. The stimulus applies each configuration only while reset is held. The one exception is the cut that is raised on purpose after discovery. A cut can only remove the token and never creates a second one, so the single-fire property still holds in that run.

// File: rtl/phase_ring_pkg.sv
package phase_ring_pkg;
  typedef enum logic [1:0] {
    ST_LAUNCH = 2'd0,
    ST_DISC   = 2'd1,
    ST_RUN    = 2'd2,
    ST_FAULT  = 2'd3
  } ring_state_e;
endpackage

// File: rtl/ring_slice.sv
module ring_slice (
  input  logic clk,
  input  logic rst,
  input  logic tok_in,
  input  logic bypass,
  input  logic cut,
  input  logic debug,
  output logic tok_out,
  output logic fire
);
  logic tok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q <= 1'b0;
      fire  <= 1'b0;
    end else begin
      tok_q <= tok_in;
      fire  <= tok_in & ~debug & ~bypass;
    end
  end

  // a bypassed slice is a wire; otherwise the registered token, unless cut
  assign tok_out = bypass ? tok_in : (tok_q & ~cut);
endmodule

// File: rtl/ring_chain.sv
module ring_chain #(
  parameter int N_SLICES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                head,
  input  logic [N_SLICES-1:0] bypass,
  input  logic [N_SLICES-1:0] cut,
  input  logic [N_SLICES-1:0] debug,
  output logic                tail,
  output logic [N_SLICES-1:0] fire
);
  logic [N_SLICES:0] link;

  assign link[0] = head;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    ring_slice u_slice (
      .clk     (clk),
      .rst     (rst),
      .tok_in  (link[i]),
      .bypass  (bypass[i]),
      .cut     (cut[i]),
      .debug   (debug[i]),
      .tok_out (link[i+1]),
      .fire    (fire[i])
    );
  end

  assign tail = link[N_SLICES];
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import phase_ring_pkg::*;
#(
  parameter int TIMEOUT = 16,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ret_in,
  output logic          tok_out,
  output logic [CW-1:0] count,
  output logic          valid,
  output logic          fault
);
  ring_state_e   state;
  logic [CW-1:0] lat_cnt;
  logic [CW-1:0] slot;
  logic [CW-1:0] slot_nx;
  logic          armed;

  assign slot_nx = (slot == count - 1'b1) ? '0 : slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LAUNCH;
      tok_out <= 1'b0;
      lat_cnt <= '0;
      count   <= '0;
      valid   <= 1'b0;
      fault   <= 1'b0;
      slot    <= '0;
      armed   <= 1'b0;
    end else begin
      case (state)
        ST_LAUNCH: begin
          tok_out <= 1'b1;
          lat_cnt <= '0;
          state   <= ST_DISC;
        end
        ST_DISC: begin
          tok_out <= 1'b0;
          if (ret_in) begin
            if (lat_cnt == '0) begin
              fault <= 1'b1;
              state <= ST_FAULT;
            end else begin
              count   <= lat_cnt;
              valid   <= 1'b1;
              tok_out <= 1'b1;
              slot    <= '0;
              armed   <= 1'b0;
              state   <= ST_RUN;
            end
          end else if (lat_cnt == CW'(TIMEOUT)) begin
            fault <= 1'b1;
            state <= ST_FAULT;
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
        ST_RUN: begin
          armed <= 1'b1;
          if (armed && (ret_in != tok_out)) begin
            fault   <= 1'b1;
            valid   <= 1'b0;
            tok_out <= 1'b0;
            state   <= ST_FAULT;
          end else begin
            slot    <= slot_nx;
            tok_out <= (slot_nx == '0);
          end
        end
        default: begin
          tok_out <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/phase_ring_seq.sv
module phase_ring_seq #(
  parameter int N_SLICES = 8,
  parameter int TIMEOUT  = 16,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SLICES-1:0] slice_bypass,
  input  logic [N_SLICES-1:0] slice_debug,
  input  logic [N_SLICES-1:0] link_cut,
  output logic                token_out,
  output logic [CW-1:0]       phase_count,
  output logic                count_valid,
  output logic                chain_fault,
  output logic [N_SLICES-1:0] slice_fire
);
  logic ring_ret;

  ring_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ret_in  (ring_ret),
    .tok_out (token_out),
    .count   (phase_count),
    .valid   (count_valid),
    .fault   (chain_fault)
  );

  ring_chain #(.N_SLICES(N_SLICES)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .head   (token_out),
    .bypass (slice_bypass),
    .cut    (link_cut),
    .debug  (slice_debug),
    .tail   (ring_ret),
    .fire   (slice_fire)
  );
endmodule

// File: rtl/ring_seq_checker.sv
module ring_seq_checker #(
  parameter int N_SLICES = 8,
  parameter int TIMEOUT  = 16,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                token_out,
  input logic [CW-1:0]       phase_count,
  input logic                count_valid,
  input logic                chain_fault,
  input logic [N_SLICES-1:0] slice_fire
);
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!chain_fault && !count_valid && !token_out)); // R1
  AST_FIRST_INJECT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> token_out); // R2
  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slice_fire)); // R9
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
    count_valid |=> $stable(phase_count)); // R5
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    count_valid |-> (phase_count != '0)); // R8
  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
    chain_fault |-> (!token_out && !count_valid)); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    chain_fault |=> chain_fault); // R10
endmodule

bind phase_ring_seq ring_seq_checker #(.N_SLICES(N_SLICES), .TIMEOUT(TIMEOUT)) u_ring_chk (
  .clk         (clk),
  .rst         (rst),
  .token_out   (token_out),
  .phase_count (phase_count),
  .count_valid (count_valid),
  .chain_fault (chain_fault),
  .slice_fire  (slice_fire)
);

// File: tb/tb_phase_ring_seq.sv
module tb_phase_ring_seq;
  localparam int NS = 8;
  localparam int TO = 16;
  localparam int CW = $clog2(TO + 1);
  localparam int NC = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] byp = '0;
  logic [NS-1:0] dbg = '0;
  logic [NS-1:0] cut = '0;
  logic          token_out;
  logic [CW-1:0] phase_count;
  logic          count_valid;
  logic          chain_fault;
  logic [NS-1:0] slice_fire;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  phase_ring_seq #(.N_SLICES(NS), .TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .slice_bypass(byp), .slice_debug(dbg), .link_cut(cut),
    .token_out(token_out), .phase_count(phase_count), .count_valid(count_valid),
    .chain_fault(chain_fault), .slice_fire(slice_fire)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int active_cnt(input logic [NS-1:0] b);
    return NS - $countones(b);
  endfunction

  function automatic int pos_of(input logic [NS-1:0] b, input int idx);
    int p = 0;
    for (int j = 0; j <= idx; j++) if (!b[j]) p++;
    return p;
  endfunction

  function automatic int first_cut_pos(input logic [NS-1:0] b, input logic [NS-1:0] c);
    for (int j = 0; j < NS; j++) if (!b[j] && c[j]) return pos_of(b, j);
    return 0;
  endfunction

  task automatic apply_reset(input logic [NS-1:0] b, input logic [NS-1:0] d, input logic [NS-1:0] c);
    @(negedge clk);
    rst = 1'b1; byp = b; dbg = d; cut = c;
    repeat (3) @(negedge clk);
    chk(!token_out && !count_valid && !chain_fault && phase_count == '0 && slice_fire == '0,
        "R1 reset state", int'({token_out, count_valid, chain_fault}), 0);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [NS-1:0] b, input logic [NS-1:0] d, input logic [NS-1:0] c);
    int k, pb;
    apply_reset(b, d, c);
    k  = active_cnt(b);
    pb = first_cut_pos(b, c);
    for (int cy = 0; cy < NC; cy++) begin
      bit te, ve, fe;
      @(negedge clk);
      if (k == 0) begin
        te = (cy == 0); ve = 1'b0; fe = (cy >= 1);
      end else if (pb != 0) begin
        te = (cy == 0); ve = 1'b0; fe = (cy >= TO + 1);
      end else begin
        te = (cy == 0) || (cy >= k + 1 && (cy - k - 1) % k == 0);
        ve = (cy >= k + 1); fe = 1'b0;
      end
      chk(token_out == te, (cy == 0) ? "R2 first token" : "R9 token period", int'(token_out), int'(te));
      chk(count_valid == ve, "R5 count_valid timing", int'(count_valid), int'(ve));
      chk(chain_fault == fe, (k == 0) ? "R8 all bypassed" : "R7 timeout fault",
          int'(chain_fault), int'(fe));
      if (ve) chk(int'(phase_count) == k, "R5 phase count", int'(phase_count), k);
      for (int i = 0; i < NS; i++) begin
        bit fx;
        int j;
        j = pos_of(b, i);
        if (b[i] || d[i]) fx = 1'b0;
        else if (pb != 0) fx = (cy == j) && (j <= pb);
        else fx = (cy == j) || (cy >= k + 1 + j && (cy - k - 1 - j) % k == 0);
        chk(slice_fire[i] == fx, b[i] ? "R4 bypassed slice" : (d[i] ? "R6 debug slice" : "R3 slice fire"),
            int'(slice_fire[i]), int'(fx));
      end
    end
  endtask

  task automatic run_midcut(input logic [NS-1:0] b, input int idx);
    int k, fault_at;
    apply_reset(b, '0, '0);
    k = active_cnt(b);
    fault_at = -1;
    for (int cy = 0; cy < 4 * k + 40; cy++) begin
      @(negedge clk);
      if (cy < 2 * k + 6)
        chk(!chain_fault, "R10 no fault before cut", int'(chain_fault), 0);
      if (fault_at >= 0) begin
        chk(chain_fault && !token_out && !count_valid, "R10 fault sticky and silent",
            int'({chain_fault, token_out, count_valid}), 4);
      end else if (chain_fault) begin
        fault_at = cy;
      end
      if (cy == 2 * k + 6) cut[idx] = 1'b1;
    end
    chk(fault_at >= 0, "R10 mid-run cut detected", fault_at, 1);
  endtask

  initial begin
    logic [NS-1:0] rb, rd, rc;
    void'($urandom(32'h5EED_2024));
    // directed corners
    run_case('0, '0, '0);                       // full chain, K=8
    run_case(8'hFE, '0, '0);                    // single active slice
    run_case(8'hFF, '0, '0);                    // everything bypassed
    run_case(8'h00, '0, 8'h10);                 // cut on active slice
    run_case(8'h22, '0, 8'h20);                 // cut on bypassed slice: ignored
    run_case(8'h0F, 8'hF0, '0);                 // all active slices in debug
    run_midcut(8'h00, 3);
    run_midcut(8'hFC, 1);
    // random configurations
    for (int n = 0; n < 24; n++) begin
      rb = NS'($urandom);
      rd = NS'($urandom);
      rc = ($urandom % 4 == 0) ? (NS'(1) << ($urandom % NS)) : '0;
      run_case(rb, rd, rc);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule